// File: doc/BRIEF.md
# Timer Input Capture Unit

This block snapshots a free-running 16-bit timer when a chosen event is seen on an external, asynchronous input pin. A 4-bit mode input picks the event: a single falling edge, a single rising edge, or every 4th or 16th rising edge counted by a small prescaler. A set of codes leaves the unit off. Each snapshot is written to a capture register and raises a sticky interrupt flag that software removes with a one-cycle clear strobe.

The pin is brought into the system clock domain through a two-stage synchronizer before edge detection. Software reads the capture register and the flag. A newer capture silently replaces an unread older one. Two behaviours are kept on purpose so that software sees them exactly as described. The prescaler is not reset when the prescale setting changes between capture modes. A change of mode can raise the flag with no real event behind it.

Top module: `capture_unit`

## Requirements
- R1: After reset the captured value is 0 and the flag is 0.
- R2: On a capture the captured value becomes the timer value present in the cycle of the event pulse, all 16 bits at once.
- R3: With mode 4'b0100 a capture happens on each falling edge of the pin, and rising edges cause none.
- R4: With mode 4'b0101 a capture happens on each rising edge of the pin, and falling edges cause none.
- R5: With mode 4'b0110, starting from a cleared prescaler, a capture happens on every 4th rising edge.
- R6: With mode 4'b0111, starting from a cleared prescaler, a capture happens on every 16th rising edge.
- R7: Every capture sets the flag. The flag stays set until a clear strobe is given. A clear strobe in the same cycle as a capture loses, and the flag stays set.
- R8: A capture made while an earlier value is unread overwrites it, with no other indication.
- R9: The prescaler count is forced to zero while the mode is not one of 4'b0100..4'b0111, including the off code 4'b0000.
- R10: Switching between 4'b0110 and 4'b0111 keeps the prescaler count. A capture fires on the rising edge at which the count is at or above the selected divisor minus one, and the count then returns to zero.
- R11: A change of the mode input to a value in 4'b0100..4'b0111 sets the flag in the following clock edge without changing the captured value.
- R12: A pin level change driven between clock edges k and k+1 yields its capture at edge k+3, loading the timer value of the cycle before that edge.
- R13: In a non-capture mode the captured value never changes, whatever the pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| capPin | input | 1 | Asynchronous event pin |
| timerVal | input | 16 | Current value of the free-running timer |
| capMode | input | 4 | Event selection and enable code |
| flagClear | input | 1 | One-cycle strobe that clears the flag |
| capValue | output | 16 | Last captured timer value |
| capFlag | output | 1 | Sticky capture interrupt flag |

## Verification
The assertions check on every cycle that a load strobe copies the timer and that the register holds otherwise. They also check that the flag stays set until cleared and that a clear loses to a capture, that no capture happens while the unit is off, that each capture lines up with an edge of the right polarity, and that the prescaler count is zero or kept across a prescale switch. Only the bench's scenarios can show the counting sequences over many edges. This covers the 4th and 16th edge captures and the early capture after a switch from the divide-by-16 setting to divide-by-4. It also covers the three-edge latency from the pin to the register and the flag raised by a mode change.

// File: rtl/capture_pkg.sv
package capture_pkg;

  localparam int unsigned MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF     = 4'b0000,
    MODE_FALL    = 4'b0100,
    MODE_RISE    = 4'b0101,
    MODE_RISE_A  = 4'b0110,
    MODE_RISE_B  = 4'b0111
  } capMode_e;

  typedef struct packed {
    logic loadCapture;
    logic raiseFlag;
  } ctrlStrobe_t;

  function automatic logic isCaptureMode(input logic [MODE_W-1:0] m);
    return (m[3:2] == 2'b01);
  endfunction

  function automatic logic isPrescaledMode(input logic [MODE_W-1:0] m);
    return (m == MODE_RISE_A) || (m == MODE_RISE_B);
  endfunction

endpackage

// File: rtl/capture_sync.sv
module capture_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import capture_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_A       = 4,
  parameter int unsigned DIV_B       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinAsync,
  input  logic [MODE_W-1:0] mode,
  output ctrlStrobe_t       strobes
);

  localparam int unsigned PS_W    = (DIV_B > 1) ? $clog2(DIV_B) : 1;
  localparam logic [PS_W-1:0] LIMIT_A = PS_W'(DIV_A - 1);
  localparam logic [PS_W-1:0] LIMIT_B = PS_W'(DIV_B - 1);

  logic              syncPin;
  logic              pinDly;
  logic              riseEv;
  logic              fallEv;
  logic [PS_W-1:0]   psCount;
  logic [PS_W-1:0]   psLimit;
  logic              psHit;
  logic              capOn;
  logic              prescaled;
  logic              fire;
  logic [MODE_W-1:0] prevMode;

  capture_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinAsync),
    .syncOut (syncPin)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinDly <= 1'b0;
    else       pinDly <= syncPin;
  end

  assign riseEv    = syncPin & ~pinDly;
  assign fallEv    = ~syncPin & pinDly;
  assign capOn     = isCaptureMode(mode);
  assign prescaled = isPrescaledMode(mode);
  assign psLimit   = (mode == MODE_RISE_B) ? LIMIT_B : LIMIT_A;
  assign psHit     = (psCount >= psLimit);

  always_comb begin
    fire = 1'b0;
    if (capOn) begin
      unique case (mode)
        MODE_FALL:   fire = fallEv;
        MODE_RISE:   fire = riseEv;
        default:     fire = riseEv & psHit;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCount <= '0;
    end else if (!capOn) begin
      psCount <= '0;
    end else if (prescaled && riseEv) begin
      psCount <= psHit ? '0 : psCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevMode <= MODE_OFF;
    else       prevMode <= mode;
  end

  assign strobes.loadCapture = fire;
  assign strobes.raiseFlag   = capOn && (mode != prevMode);

  p_ps_cleared_r9: assert property (@(posedge clk) disable iff (!rstN)
    !isCaptureMode(mode) |=> (psCount == '0));

  p_off_no_capture_r13: assert property (@(posedge clk) disable iff (!rstN)
    !isCaptureMode(mode) |-> !strobes.loadCapture);

  p_fall_needs_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_FALL && strobes.loadCapture) |-> ($past(syncPin) && !syncPin));

  p_rise_needs_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isCaptureMode(mode) && mode != MODE_FALL && strobes.loadCapture)
      |-> (!$past(syncPin) && syncPin));

  p_ps_kept_on_switch_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == MODE_RISE_B && mode == MODE_RISE_A && !$past(riseEv))
      |-> (psCount == $past(psCount)));

endmodule

// File: rtl/capture_datapath.sv
module capture_datapath
  import capture_pkg::*;
#(
  parameter int unsigned TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic               flagClear,
  input  ctrlStrobe_t        strobes,
  output logic [TIMER_W-1:0] capValue,
  output logic               capFlag
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    capValue <= '0;
    else if (strobes.loadCapture) capValue <= timerVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         capFlag <= 1'b0;
    else if (strobes.loadCapture || strobes.raiseFlag) capFlag <= 1'b1;
    else if (flagClear)                                capFlag <= 1'b0;
  end

  p_capture_loads_timer_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCapture |=> (capValue == $past(timerVal)));

  p_hold_without_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadCapture |=> $stable(capValue));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !flagClear) |=> capFlag);

  p_flag_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadCapture || strobes.raiseFlag) |=> capFlag);

  p_flag_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !strobes.loadCapture && !strobes.raiseFlag) |=> !capFlag);

endmodule

// File: rtl/capture_unit.sv
module capture_unit
  import capture_pkg::*;
#(
  parameter int unsigned TIMER_W     = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_A       = 4,
  parameter int unsigned DIV_B       = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               capPin,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic [MODE_W-1:0]  capMode,
  input  logic               flagClear,
  output logic [TIMER_W-1:0] capValue,
  output logic               capFlag
);

  ctrlStrobe_t strobes;

  capture_ctrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .DIV_A       (DIV_A),
    .DIV_B       (DIV_B)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pinAsync (capPin),
    .mode     (capMode),
    .strobes  (strobes)
  );

  capture_datapath #(.TIMER_W(TIMER_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .timerVal  (timerVal),
    .flagClear (flagClear),
    .strobes   (strobes),
    .capValue  (capValue),
    .capFlag   (capFlag)
  );

endmodule

// File: tb/test_capture_unit.sv
`timescale 1ns/1ps
module test_capture_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        capPin = 1'b0;
  logic [15:0] timerVal;
  logic [3:0]  capMode = 4'b0000;
  logic        flagClear = 1'b0;
  logic [15:0] capValue;
  logic        capFlag;

  int total = 0;
  int bad = 0;
  int capCount = 0;
  logic [15:0] lastCap = '0;
  bit finished = 0;

  // bench model state
  logic m1, m2, m3;
  logic [3:0]  mCnt;
  logic [3:0]  mPrev;
  logic [15:0] mVal;
  logic        mFlag;

  always #4 clk = ~clk;

  capture_unit i_capture_unit (
    .clk(clk), .rstN(rstN), .capPin(capPin), .timerVal(timerVal),
    .capMode(capMode), .flagClear(flagClear),
    .capValue(capValue), .capFlag(capFlag)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) timerVal <= 16'd0;
    else       timerVal <= timerVal + 16'd1;
  end

  function automatic bit benchCapMode(input logic [3:0] m);
    return (m >= 4'd4) && (m <= 4'd7);
  endfunction

  function automatic logic [3:0] benchLimit(input logic [3:0] m);
    return (m == 4'd7) ? 4'd15 : 4'd3;
  endfunction

  always @(posedge clk or negedge rstN) begin
    logic r, f, hit;
    if (!rstN) begin
      m1 <= 0; m2 <= 0; m3 <= 0; mCnt <= 0; mPrev <= 0; mVal <= 0; mFlag <= 0;
    end else begin
      r = m2 & ~m3;
      f = ~m2 & m3;
      hit = 0;
      if (capMode == 4'd4) hit = f;
      else if (capMode == 4'd5) hit = r;
      else if (capMode == 4'd6 || capMode == 4'd7) hit = r && (mCnt >= benchLimit(capMode));
      if (!benchCapMode(capMode)) mCnt <= 0;
      else if ((capMode == 4'd6 || capMode == 4'd7) && r)
        mCnt <= (mCnt >= benchLimit(capMode)) ? 4'd0 : mCnt + 4'd1;
      if (hit) mVal <= timerVal;
      if (hit || (benchCapMode(capMode) && capMode != mPrev)) mFlag <= 1;
      else if (flagClear) mFlag <= 0;
      m1 <= capPin; m2 <= m1; m3 <= m2; mPrev <= capMode;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mid-cycle monitor: capture counting and model comparison
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      if (capValue != lastCap) capCount++;
      lastCap = capValue;
      chk(capValue == mVal, "R2 value vs model", capValue, mVal);
      chk(capFlag == mFlag, "R7 flag vs model", capFlag, mFlag);
    end
  end

  task automatic pulse();
    @(negedge clk) capPin = 1'b1;
    repeat (4) @(negedge clk);
    capPin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) pulse();
  endtask

  task automatic setMode(input logic [3:0] m);
    @(negedge clk) capMode = m;
    repeat (2) @(negedge clk);
  endtask

  task automatic clearIt();
    @(negedge clk) flagClear = 1'b1;
    @(negedge clk) flagClear = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int c0;
    logic [15:0] t, held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(capValue == 16'd0, "R1 value", capValue, 0);
    chk(capFlag == 1'b0, "R1 flag", capFlag, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(capValue == 16'd0 && !capFlag, "R1 after release", capValue, 0);

    // R11: mode change raises flag, value untouched
    held = capValue;
    @(negedge clk) capMode = 4'd4;
    @(negedge clk);
    chk(capFlag == 1'b1, "R11 flag on mode change", capFlag, 1);
    chk(capValue == held, "R11 value unchanged", capValue, held);
    clearIt();
    @(negedge clk);
    chk(capFlag == 1'b0, "R7 clear alone", capFlag, 0);

    // R3: falling mode
    c0 = capCount;
    @(negedge clk) capPin = 1'b1;
    repeat (5) @(negedge clk);
    chk(capCount == c0, "R3 rise ignored", capCount - c0, 0);
    capPin = 1'b0;
    repeat (5) @(negedge clk);
    chk(capCount == c0 + 1, "R3 fall captures", capCount - c0, 1);
    chk(capFlag == 1'b1, "R7 capture sets flag", capFlag, 1);

    // R4: rising mode
    setMode(4'd5);
    c0 = capCount;
    @(negedge clk) capPin = 1'b1;
    repeat (5) @(negedge clk);
    chk(capCount == c0 + 1, "R4 rise captures", capCount - c0, 1);
    capPin = 1'b0;
    repeat (5) @(negedge clk);
    chk(capCount == c0 + 1, "R4 fall ignored", capCount - c0, 1);

    // R12: latency and value
    @(negedge clk) capPin = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) t = timerVal;
    chk(capValue != t, "R12 not yet", capValue, t);
    @(negedge clk);
    chk(capValue == t, "R12 latency value", capValue, t);
    capPin = 1'b0;
    repeat (4) @(negedge clk);

    // R7: clear loses to simultaneous capture
    clearIt();
    @(negedge clk) capPin = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) flagClear = 1'b1;
    @(negedge clk) flagClear = 1'b0;
    chk(capFlag == 1'b1, "R7 clear loses", capFlag, 1);
    capPin = 1'b0;
    repeat (4) @(negedge clk);

    // R8: overwrite
    pulse();
    held = capValue;
    pulse();
    chk(capValue != held && capValue == mVal, "R8 overwrite", capValue, mVal);

    // R5: every 4th
    setMode(4'd0);
    setMode(4'd6);
    c0 = capCount;
    pulses(3);
    chk(capCount == c0, "R5 three edges", capCount - c0, 0);
    pulse();
    chk(capCount == c0 + 1, "R5 fourth edge", capCount - c0, 1);
    pulses(4);
    chk(capCount == c0 + 2, "R5 eighth edge", capCount - c0, 2);

    // R6: every 16th
    setMode(4'd0);
    setMode(4'd7);
    c0 = capCount;
    pulses(15);
    chk(capCount == c0, "R6 fifteen edges", capCount - c0, 0);
    pulse();
    chk(capCount == c0 + 1, "R6 sixteenth edge", capCount - c0, 1);

    // R9: off clears prescaler
    setMode(4'd0);
    setMode(4'd6);
    pulses(2);
    setMode(4'd0);
    setMode(4'd6);
    c0 = capCount;
    pulses(3);
    chk(capCount == c0, "R9 count restarted", capCount - c0, 0);
    pulse();
    chk(capCount == c0 + 1, "R9 capture after four", capCount - c0, 1);

    // R10: switch 16 -> 4 keeps count, early capture
    setMode(4'd0);
    setMode(4'd7);
    pulses(6);
    setMode(4'd6);
    c0 = capCount;
    pulse();
    chk(capCount == c0 + 1, "R10 early capture", capCount - c0, 1);
    pulses(3);
    chk(capCount == c0 + 1, "R10 wrapped to zero", capCount - c0, 1);
    pulse();
    chk(capCount == c0 + 2, "R10 next after four", capCount - c0, 2);

    // R13: non-capture modes
    setMode(4'd0);
    held = capValue;
    pulses(3);
    chk(capValue == held, "R13 off holds", capValue, held);
    setMode(4'd13);
    pulses(3);
    chk(capValue == held, "R13 other code holds", capValue, held);

    // random phase against bench model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(2) == 0) capPin = ~capPin;
      flagClear = ($urandom_range(7) == 0);
      if ($urandom_range(49) == 0) begin
        case ($urandom_range(5))
          0: capMode = 4'd0;
          1: capMode = 4'd4;
          2: capMode = 4'd5;
          3: capMode = 4'd6;
          4: capMode = 4'd7;
          default: capMode = 4'($urandom_range(15));
        endcase
      end
    end
    flagClear = 1'b0;
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule